// File: doc/BRIEF.md
# Modulated Fractional Baud Generator

This block makes the bit timing for an asynchronous serial frame when the input clock is slow. It also works when the ideal ratio between the input clock and the bit rate is not an integer. Each bit lasts a programmable whole number of input clocks. One extra clock may be added to each bit. Whether the extra clock is added is chosen in turn by the bits of an 8-bit modulation pattern. Over a frame, the average period therefore falls between two integers. Because the extra clocks are spread across the frame, the edge-position error stays small.

A frame begins with a one-cycle frame-start strobe. At that strobe the block captures the divisor and the pattern. It then times a fixed number of bit periods, twelve by default: start bit, eight data bits, parity and two stop bits. It marks the last clock of each bit with a boundary tick and the middle of each bit with a sample strobe. It also reports which bit of the frame is being timed. The transmit and receive sides can both use the same generator. The transmit side shifts on the boundary tick, and the receive side samples on the mid-bit strobe.

Top module: `frac_baud_gen`

## Requirements
- R1: While reset is high, and after it until the first frame start, `bit_tick` and `sample_tick` are 0 and `bit_index` is 0.
- R2: Bit k of a frame lasts `divisor + pattern[k mod 8]` input clocks. `bit_tick` is a one-cycle pulse on the last clock of each bit, and `bit_index` advances by one after each tick.
- R3: The pattern is used least significant bit first. Bit 0 of the pattern applies to the first bit period (the start bit). Bit 8 of the frame uses pattern bit 0 again.
- R4: With divisor 13 and pattern 0x6B, the k-th boundary tick (k = 0..11) falls 13(k+1)+E_k clocks after the sampled frame start, where E = 1,2,2,3,3,4,5,5,6,7,7,8. Every edge stays within 6 % of a bit of the ideal 32768/2400 rate.
- R5: `sample_tick` pulses once per bit, on clock floor(P/2) of a bit of length P. Clocks are counted from 0 at the first clock of the bit.
- R6: `bit_index` stays within 0..FRAME_BITS-1. After the tick of the last bit the frame ends: no further ticks occur and `bit_index` returns to 0.
- R7: A frame-start strobe during a frame restarts timing at once, with bit 0, pattern bit 0 and a fresh count.
- R8: Changes to `divisor` or `mod_pattern` during a frame have no effect until the next frame start.
- R9: When a bit's length `divisor + pattern bit` would be 0, that bit lasts one clock.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Input (bit-rate) clock |
| rst | input | 1 | Synchronous active-high reset |
| divisor | input | DIV_W | Whole-number clocks per bit |
| mod_pattern | input | PAT_W | Per-bit extra-clock pattern, LSB first |
| frame_start | input | 1 | One-cycle strobe that starts or restarts a frame |
| bit_tick | output | 1 | Pulse on the last clock of each bit |
| sample_tick | output | 1 | Pulse at the middle of each bit |
| bit_index | output | $clog2(FRAME_BITS) | Bit currently being timed |

## Verification
The bench numbers cycles from the clock edge that samples `frame_start`. The first clock of bit 0 is cycle 1. Tick k is due in cycle S_k, the running sum of the bit lengths. The sample strobe of bit k is due in cycle S_{k-1}+1+floor(P_k/2). `bit_index` holds k in the cycles from S_{k-1}+1 through S_k. All outputs are decoded straight from registers, so they are sampled on the falling edge of the same cycle they are due. For every cycle of a frame, and for a few quiet cycles after it, the bench compares all three outputs against these sums, which it computes from the divisor and pattern alone.

// File: rtl/frac_baud_pkg.sv
package frac_baud_pkg;

    localparam int unsigned DEF_DIV_W      = 16;
    localparam int unsigned DEF_PAT_W      = 8;
    localparam int unsigned DEF_FRAME_BITS = 12;

    typedef enum logic {
        FR_IDLE = 1'b0,
        FR_RUN  = 1'b1
    } frame_state_e;

    // Length of one bit: whole divisor plus the selected extra clock,
    // never shorter than a single clock.
    function automatic int unsigned eff_period(input int unsigned whole, input logic extra);
        int unsigned len;
        len = whole + int'(extra);
        return (len == 0) ? 1 : len;
    endfunction

    function automatic int unsigned width_of(input int unsigned count);
        return (count > 1) ? $clog2(count) : 1;
    endfunction

endpackage

// File: rtl/fb_bit_seq.sv
module fb_bit_seq
    import frac_baud_pkg::*;
#(
    parameter int unsigned PAT_W      = DEF_PAT_W,
    parameter int unsigned FRAME_BITS = DEF_FRAME_BITS,
    localparam int unsigned IDX_W     = width_of(FRAME_BITS),
    localparam int unsigned PTR_W     = width_of(PAT_W)
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               start,
    input  logic               bit_done,
    input  logic [PAT_W-1:0]   pattern,
    output frame_state_e       state,
    output logic [IDX_W-1:0]   bit_idx,
    output logic               mod_bit
);

    localparam logic [IDX_W-1:0] LAST_IDX = IDX_W'(FRAME_BITS - 1);
    localparam logic [PTR_W-1:0] LAST_PTR = PTR_W'(PAT_W - 1);

    logic [PTR_W-1:0] ptr;

    always_ff @(posedge clk) begin
        if (rst) begin
            state   <= FR_IDLE;
            bit_idx <= '0;
            ptr     <= '0;
        end else if (start) begin
            state   <= FR_RUN;
            bit_idx <= '0;
            ptr     <= '0;
        end else if (state == FR_RUN && bit_done) begin
            if (bit_idx == LAST_IDX) begin
                state   <= FR_IDLE;
                bit_idx <= '0;
                ptr     <= '0;
            end else begin
                bit_idx <= bit_idx + IDX_W'(1);
                ptr     <= (ptr == LAST_PTR) ? '0 : ptr + PTR_W'(1);
            end
        end
    end

    generate
        if (PAT_W == 1) begin : g_single
            assign mod_bit = pattern[0];
        end else begin : g_multi
            assign mod_bit = pattern[ptr];
        end
    endgenerate

endmodule

// File: rtl/fb_period_cnt.sv
module fb_period_cnt #(
    parameter int unsigned PER_W = 17
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             start,
    input  logic             running,
    input  logic [PER_W-1:0] period,
    output logic             bit_done,
    output logic             half_hit
);

    logic [PER_W-1:0] cnt;
    logic [PER_W-1:0] last_cnt;
    logic [PER_W-1:0] mid_cnt;

    assign last_cnt = period - PER_W'(1);
    assign mid_cnt  = period >> 1;
    assign bit_done = running && (cnt == last_cnt);
    assign half_hit = running && (cnt == mid_cnt);

    always_ff @(posedge clk) begin
        if (rst || start) begin
            cnt <= '0;
        end else if (running) begin
            cnt <= bit_done ? '0 : cnt + PER_W'(1);
        end else begin
            cnt <= '0;
        end
    end

endmodule

// File: rtl/frac_baud_gen.sv
module frac_baud_gen
    import frac_baud_pkg::*;
#(
    parameter int unsigned DIV_W      = DEF_DIV_W,
    parameter int unsigned PAT_W      = DEF_PAT_W,
    parameter int unsigned FRAME_BITS = DEF_FRAME_BITS,
    localparam int unsigned IDX_W     = width_of(FRAME_BITS),
    localparam int unsigned PER_W     = DIV_W + 1
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [DIV_W-1:0]  divisor,
    input  logic [PAT_W-1:0]  mod_pattern,
    input  logic              frame_start,
    output logic              bit_tick,
    output logic              sample_tick,
    output logic [IDX_W-1:0]  bit_index
);

    typedef struct packed {
        logic [DIV_W-1:0] whole;
        logic [PAT_W-1:0] pat;
    } frame_cfg_t;

    frame_cfg_t       cfg;
    frame_state_e     state;
    logic             mod_bit;
    logic             bit_done;
    logic             half_hit;
    logic [PER_W-1:0] period;

    // Settings are frozen for the whole frame.
    always_ff @(posedge clk) begin
        if (rst) begin
            cfg <= '0;
        end else if (frame_start) begin
            cfg.whole <= divisor;
            cfg.pat   <= mod_pattern;
        end
    end

    assign period = PER_W'(eff_period(32'(cfg.whole), mod_bit));

    fb_bit_seq #(
        .PAT_W      (PAT_W),
        .FRAME_BITS (FRAME_BITS)
    ) u_seq (
        .clk      (clk),
        .rst      (rst),
        .start    (frame_start),
        .bit_done (bit_done),
        .pattern  (cfg.pat),
        .state    (state),
        .bit_idx  (bit_index),
        .mod_bit  (mod_bit)
    );

    fb_period_cnt #(
        .PER_W (PER_W)
    ) u_cnt (
        .clk      (clk),
        .rst      (rst),
        .start    (frame_start),
        .running  (state == FR_RUN),
        .period   (period),
        .bit_done (bit_done),
        .half_hit (half_hit)
    );

    assign bit_tick    = bit_done;
    assign sample_tick = half_hit;

endmodule

// File: rtl/frac_baud_gen_chk.sv
module frac_baud_gen_chk #(
    parameter int unsigned FRAME_BITS = 12,
    parameter int unsigned IDX_W      = 4
) (
    input logic             clk,
    input logic             rst,
    input logic             frame_start,
    input logic             bit_tick,
    input logic             sample_tick,
    input logic [IDX_W-1:0] bit_index
);

    localparam logic [IDX_W-1:0] LAST = IDX_W'(FRAME_BITS - 1);

    assert_reset_idle_R1: assert property (@(posedge clk)
        rst |=> (!bit_tick && !sample_tick && bit_index == '0));

    assert_index_range_R6: assert property (@(posedge clk) disable iff (rst)
        bit_index <= LAST);

    assert_index_step_R2: assert property (@(posedge clk) disable iff (rst)
        (bit_tick && !frame_start && bit_index != LAST)
        |=> (bit_index == $past(bit_index) + IDX_W'(1)));

    assert_frame_end_R6: assert property (@(posedge clk) disable iff (rst)
        (bit_tick && !frame_start && bit_index == LAST)
        |=> (bit_index == '0 && !bit_tick && !sample_tick));

    assert_restart_R7: assert property (@(posedge clk) disable iff (rst)
        frame_start |=> (bit_index == '0));

    assert_one_sample_R5: assert property (@(posedge clk) disable iff (rst)
        (sample_tick && !bit_tick && !frame_start) |=> !sample_tick);

endmodule

bind frac_baud_gen frac_baud_gen_chk #(
    .FRAME_BITS (FRAME_BITS),
    .IDX_W      (IDX_W)
) u_chk (
    .clk         (clk),
    .rst         (rst),
    .frame_start (frame_start),
    .bit_tick    (bit_tick),
    .sample_tick (sample_tick),
    .bit_index   (bit_index)
);

// File: tb/frac_baud_gen_bench.sv
module frac_baud_gen_bench;

    localparam int NBITS = 12;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [15:0] divisor = '0;
    logic [7:0]  mod_pattern = '0;
    logic        frame_start = 1'b0;
    logic        bit_tick;
    logic        sample_tick;
    logic [3:0]  bit_index;

    int checks = 0;
    int fails  = 0;
    int obs [NBITS];

    always #5 clk = ~clk;

    frac_baud_gen u_frac_baud_gen (
        .clk         (clk),
        .rst         (rst),
        .divisor     (divisor),
        .mod_pattern (mod_pattern),
        .frame_start (frame_start),
        .bit_tick    (bit_tick),
        .sample_tick (sample_tick),
        .bit_index   (bit_index)
    );

    task automatic report(input string tag);
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    endtask

    // R1: idle outputs during and after reset
    task automatic t_reset();
        rst = 1'b1;
        for (int i = 0; i < 3; i++) begin
            @(negedge clk);
            checks++;
            if (bit_tick || sample_tick || bit_index != 0) begin
                fails++;
                $display("FAIL R1 in reset: tick=%0b sample=%0b idx=%0d expected 0 0 0",
                         bit_tick, sample_tick, bit_index);
            end
        end
        rst = 1'b0;
        for (int i = 0; i < 10; i++) begin
            @(negedge clk);
            checks++;
            if (bit_tick || sample_tick || bit_index != 0) begin
                fails++;
                $display("FAIL R1 after reset: tick=%0b sample=%0b idx=%0d expected 0 0 0",
                         bit_tick, sample_tick, bit_index);
            end
        end
    endtask

    // Runs one frame and checks every cycle. stop_n > 0 ends early;
    // chg_n > 0 alters the inputs after that cycle (R8).
    task automatic run_frame(input int div, input int pat, input int stop_n,
                             input int chg_n, input string tag);
        int len [NBITS];
        int ends [NBITS];
        int acc;
        int last_n;
        int nt;
        acc = 0;
        for (int k = 0; k < NBITS; k++) begin
            len[k] = div + ((pat >> (k % 8)) & 1);
            if (len[k] == 0) len[k] = 1;
            acc += len[k];
            ends[k] = acc;
        end
        last_n = (stop_n > 0) ? stop_n : ends[NBITS-1] + 6;
        nt = 0;
        @(negedge clk);
        divisor     = 16'(div);
        mod_pattern = 8'(pat);
        frame_start = 1'b1;
        @(negedge clk);
        frame_start = 1'b0;
        for (int n = 1; n <= last_n; n++) begin
            logic e_tick;
            logic e_samp;
            int   e_idx;
            e_tick = 1'b0;
            e_samp = 1'b0;
            e_idx  = 0;
            for (int k = 0; k < NBITS; k++) begin
                int first;
                first = (k == 0) ? 1 : ends[k-1] + 1;
                if (n == ends[k]) e_tick = 1'b1;
                if (n == first + len[k] / 2) e_samp = 1'b1;
                if (n >= first && n <= ends[k]) e_idx = k;
            end
            checks++;
            if (bit_tick !== e_tick || sample_tick !== e_samp || int'(bit_index) != e_idx) begin
                fails++;
                $display("FAIL %s cycle %0d: tick=%0b sample=%0b idx=%0d expected %0b %0b %0d",
                         tag, n, bit_tick, sample_tick, bit_index, e_tick, e_samp, e_idx);
            end
            if (bit_tick && nt < NBITS) begin
                obs[nt] = n;
                nt++;
            end
            if (n == chg_n) begin
                divisor     = 16'(div + 3);
                mod_pattern = ~8'(pat);
            end
            if (n < last_n) @(negedge clk);
        end
    endtask

    // R4: edge positions for divisor 13, pattern 0x6B
    task automatic t_edges();
        int  extra [NBITS] = '{1, 2, 2, 3, 3, 4, 5, 5, 6, 7, 7, 8};
        real ideal;
        real err;
        ideal = 32768.0 / 2400.0;
        for (int k = 0; k < NBITS; k++) obs[k] = -1;
        run_frame(13, 'h6B, 0, 0, "R4 frame");
        for (int k = 0; k < NBITS; k++) begin
            checks++;
            if (obs[k] != 13 * (k + 1) + extra[k]) begin
                fails++;
                $display("FAIL R4 edge %0d: at %0d expected %0d", k, obs[k], 13 * (k + 1) + extra[k]);
            end
            err = (real'(obs[k]) - real'(k + 1) * ideal) / ideal * 100.0;
            if (err < 0.0) err = -err;
            checks++;
            if (err > 6.0) begin
                fails++;
                $display("FAIL R4 error bit %0d: %f percent expected below 6", k, err);
            end
        end
    endtask

    task automatic t_basic();
        run_frame(13, 'h6B, 0, 0, "R2 R5 R6 div13");
        run_frame(6, 'h00, 0, 0, "R2 R5 no-extra");
        run_frame(5, 'hFF, 0, 0, "R2 R5 all-extra");
    endtask

    task automatic t_order();
        run_frame(4, 'h01, 0, 0, "R3 lsb-first wrap");
        run_frame(4, 'h80, 0, 0, "R3 msb-last");
    endtask

    task automatic t_restart();
        run_frame(7, 'hA5, 40, 0, "R7 before restart");
        run_frame(7, 'hA5, 0, 0, "R7 after restart");
        run_frame(3, 'h5A, 17, 0, "R7 before short restart");
        run_frame(9, 'h3C, 0, 0, "R7 restart new setting");
    endtask

    task automatic t_hold();
        run_frame(8, 'h96, 0, 20, "R8 mid-frame change");
    endtask

    task automatic t_zero();
        run_frame(0, 'h00, 0, 0, "R9 zero length");
        run_frame(0, 'h33, 0, 0, "R9 zero divisor");
        run_frame(1, 'h00, 0, 0, "R9 one clock");
    endtask

    initial begin
        t_reset();
        t_basic();
        t_edges();
        t_order();
        t_restart();
        t_hold();
        t_zero();
        report("done");
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        fails++;
        $display("FAIL watchdog: run did not finish, expected completion");
        report("watchdog");
        $finish;
    end

endmodule